// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a 16-key matrix arranged as four columns and four rows. The rows are pulled up on the board. The block drives exactly one column low at a time and leaves the other three high. It steps that low column across the matrix in a fixed order. Each column is held for a programmable settling time. At the end of that time the block looks at the synchronized row lines. A row that reads low means the key where that row crosses the active column is pressed.

When a press is seen, the block emits a four-bit key code with a one-cycle valid strobe. The column number sits in the upper two bits and the row number in the lower two. The block then parks on that column until every row reads high again. After release it waits a fixed hold-off period, counted in clock cycles, to ride out contact bounce. Scanning then restarts from the first column.

The row lines come from the outside world. They pass through a two-flop synchronizer before any decision uses them. For that reason the settling time must be at least three cycles.

Top module: `keymatrix_scan`

## Requirements
- R1: Reset is synchronous and active high. During and right after reset the column drive is 4'b1110, the key code is 0 and the valid strobe is low.
- R2: With no key pressed, the column drive cycles through 4'b1110, 4'b1101, 4'b1011, 4'b0111 and then repeats. Exactly one column line is low at any time.
- R3: With no key pressed, each column pattern is held for exactly SETTLE_CYC clock cycles.
- R4: A pressed key is reported by a one-cycle pulse on key_valid. key_code[3:2] holds the index of the column driven low (0 for 4'b1110 through 3 for 4'b0111). key_code[1:0] holds the index of the low row line (row_i bit 0 through 3).
- R5: When several row lines are low in the active column, the lowest-numbered row is reported.
- R6: After a report, the column drive stays on the reported column. No further report occurs while any row line stays low.
- R7: Once all rows read high again, the column drive stays unchanged and no report occurs for HOLDOFF_CYC cycles.
- R8: When the hold-off ends, scanning restarts with column pattern 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_i | input | 4 | Row sense lines, pulled up, low when a key in the active column is pressed |
| col_o | output | 4 | Column drive, one line low at a time |
| key_code | output | 4 | {column index, row index} of the last reported key |
| key_valid | output | 1 | One-cycle strobe marking a new key_code |

## Verification
The hardest path to reach from the ports is the hold-off that follows a release. It is invisible until the bench times the gap between letting go of a key and the next column step. Both edges of that gap are shifted by the synchronizer latency. The bench models the keypad as a grid that closes a row to a column only while that column is driven low. It reports a key in the last column and releases it, then checks that the drive stays frozen until just before the hold-off expires. It then presses a key in column 0 and checks that the scan restarts there and that the resulting report lands inside a narrow window after the hold-off.

// File: rtl/kms_pkg.sv
package kms_pkg;

  typedef enum logic [1:0] {
    ST_SETTLE  = 2'd0,
    ST_RELEASE = 2'd1,
    ST_HOLD    = 2'd2
  } scan_state_t;

endpackage

// File: rtl/kms_row_sync.sv
module kms_row_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '1;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '1;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/kms_row_prio.sv
module kms_row_prio #(
  parameter int WIDTH = 4,
  localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] rows_n_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o
);

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int r = WIDTH - 1; r >= 0; r--) begin
      if (!rows_n_i[r]) begin
        hit_o = 1'b1;
        idx_o = IW'(r);
      end
    end
  end

endmodule

// File: rtl/kms_scan_ctrl.sv
module kms_scan_ctrl
  import kms_pkg::*;
#(
  parameter int NUM_COLS    = 4,
  parameter int NUM_ROWS    = 4,
  parameter int SETTLE_CYC  = 16,
  parameter int HOLDOFF_CYC = 1000,
  localparam int CB = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int RB = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int MAXC = (SETTLE_CYC > HOLDOFF_CYC) ? SETTLE_CYC : HOLDOFF_CYC,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ROWS-1:0] rows_i,
  input  logic                hit_i,
  input  logic [RB-1:0]       row_idx_i,
  output logic [NUM_COLS-1:0] col_o,
  output logic [CB+RB-1:0]    code_o,
  output logic                valid_o
);

  scan_state_t   state_q;
  logic [CB-1:0] col_q;
  logic [CW-1:0] cnt_q;
  logic [CB-1:0] col_nxt;

  assign col_nxt = (col_q == CB'(NUM_COLS - 1)) ? '0 : col_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SETTLE;
      col_q   <= '0;
      cnt_q   <= '0;
      col_o   <= ~NUM_COLS'(1);
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (state_q)
        ST_SETTLE: begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            cnt_q <= '0;
            if (hit_i) begin
              code_o  <= {col_q, row_idx_i};
              valid_o <= 1'b1;
              state_q <= ST_RELEASE;
            end else begin
              col_q <= col_nxt;
              col_o <= ~(NUM_COLS'(1) << col_nxt);
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RELEASE: begin
          if (&rows_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
          end
        end
        ST_HOLD: begin
          if (cnt_q == CW'(HOLDOFF_CYC - 1)) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
            col_q   <= '0;
            col_o   <= ~NUM_COLS'(1);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_SETTLE;
      endcase
    end
  end

endmodule

// File: rtl/keymatrix_scan.sv
module keymatrix_scan #(
  parameter int SETTLE_CYC  = 16,
  parameter int HOLDOFF_CYC = 12_500_000,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_COLS = 4,
  localparam int NUM_ROWS = 4,
  localparam int CB = $clog2(NUM_COLS),
  localparam int RB = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ROWS-1:0] row_i,
  output logic [NUM_COLS-1:0] col_o,
  output logic [CB+RB-1:0]    key_code,
  output logic                key_valid
);

  logic [NUM_ROWS-1:0] rows_s;
  logic                hit;
  logic [RB-1:0]       row_idx;

  kms_row_sync #(.WIDTH(NUM_ROWS), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i (row_i),
    .q_o (rows_s)
  );

  kms_row_prio #(.WIDTH(NUM_ROWS)) i_prio (
    .rows_n_i (rows_s),
    .hit_o    (hit),
    .idx_o    (row_idx)
  );

  kms_scan_ctrl #(
    .NUM_COLS    (NUM_COLS),
    .NUM_ROWS    (NUM_ROWS),
    .SETTLE_CYC  (SETTLE_CYC),
    .HOLDOFF_CYC (HOLDOFF_CYC)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rows_i    (rows_s),
    .hit_i     (hit),
    .row_idx_i (row_idx),
    .col_o     (col_o),
    .code_o    (key_code),
    .valid_o   (key_valid)
  );

endmodule

// File: rtl/kms_scan_chk.sv
module kms_scan_chk #(
  parameter int NCOL = 4,
  parameter int NROW = 4,
  localparam int CB = $clog2(NCOL),
  localparam int RB = $clog2(NROW)
) (
  input logic            clk,
  input logic            rst,
  input logic [NCOL-1:0] col_o,
  input logic [CB+RB-1:0] key_code,
  input logic            key_valid
);

  // R2
  one_col_low_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~col_o) == 1);

  // R2 R8
  col_order_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(col_o) |-> (col_o == {$past(col_o[NCOL-2:0]), 1'b1}) ||
                        (col_o == ~NCOL'(1)));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  // R4
  code_col_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> col_o == ~(NCOL'(1) << key_code[CB+RB-1:RB]));

  // R6
  park_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> $stable(col_o));

endmodule

bind keymatrix_scan kms_scan_chk #(.NCOL(NUM_COLS), .NROW(NUM_ROWS)) i_scan_chk (
  .clk       (clk),
  .rst       (rst),
  .col_o     (col_o),
  .key_code  (key_code),
  .key_valid (key_valid)
);

// File: tb/test_keymatrix_scan.sv
`timescale 1ns/1ps
module test_keymatrix_scan;

  localparam int SETTLE = 6;
  localparam int HOLD   = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_i;
  logic [3:0] col_o;
  logic [3:0] key_code;
  logic       key_valid;
  logic [15:0] key_down = '0;  // bit c*4+r: key at column c, row r

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  keymatrix_scan #(.SETTLE_CYC(SETTLE), .HOLDOFF_CYC(HOLD)) i_keymatrix_scan (
    .clk(clk), .rst(rst), .row_i(row_i),
    .col_o(col_o), .key_code(key_code), .key_valid(key_valid)
  );

  // Keypad model: a closed key pulls its row low while its column is driven low
  always_comb begin
    row_i = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (key_down[c*4+r] && !col_o[c]) row_i[r] = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(input int limit, output bit seen, output int cyc);
    seen = 0; cyc = 0;
    while (!seen && cyc < limit) begin
      @(negedge clk); cyc++;
      if (key_valid) seen = 1;
    end
  endtask

  task automatic release_all();
    @(negedge clk) key_down = '0;
    repeat (HOLD + 20) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(col_o == 4'b1110, "R1 col", col_o, 4'b1110);
    chk(key_code == 4'h0, "R1 code", key_code, 0);
    chk(key_valid == 1'b0, "R1 valid", key_valid, 0);
  endtask

  task automatic t_idle_scan();
    logic [3:0] exp_seq [4] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111};
    logic [3:0] prev;
    int idx = 1;
    bit any_valid = 0;
    prev = col_o;
    while (col_o == prev) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      int dwell = 0;
      chk(col_o == exp_seq[idx], "R2 order", col_o, exp_seq[idx]);
      prev = col_o;
      while (col_o == prev && dwell < 100) begin
        @(negedge clk); dwell++;
        if (key_valid) any_valid = 1;
      end
      chk(dwell == SETTLE, "R3 dwell", dwell, SETTLE);
      idx = (idx + 1) % 4;
    end
    chk(!any_valid, "R2 no report idle", any_valid, 0);
  endtask

  task automatic t_single();
    bit seen; int cyc;
    @(negedge clk) key_down[2*4+1] = 1'b1;
    wait_valid(200, seen, cyc);
    chk(seen, "R4 valid", seen, 1);
    chk(key_code == 4'h9, "R4 code", key_code, 4'h9);
    @(negedge clk);
    chk(!key_valid, "R4 one-cycle", key_valid, 0);
    release_all();
  endtask

  task automatic t_multi_row();
    bit seen; int cyc;
    @(negedge clk) begin key_down[1*4+1] = 1'b1; key_down[1*4+3] = 1'b1; end
    wait_valid(200, seen, cyc);
    chk(seen && key_code == 4'h5, "R5 rows1,3", key_code, 4'h5);
    release_all();
    @(negedge clk) begin key_down[3*4+2] = 1'b1; key_down[3*4+3] = 1'b1; end
    wait_valid(200, seen, cyc);
    chk(seen && key_code == 4'hE, "R5 rows2,3", key_code, 4'hE);
    release_all();
  endtask

  task automatic t_held();
    bit seen; int cyc; int extra = 0;
    @(negedge clk) key_down[0*4+3] = 1'b1;
    wait_valid(200, seen, cyc);
    chk(seen && key_code == 4'h3, "R4 code col0", key_code, 4'h3);
    repeat (1000) begin
      @(negedge clk);
      if (key_valid) extra++;
    end
    chk(extra == 0, "R6 single report", extra, 0);
    chk(col_o == 4'b1110, "R6 parked", col_o, 4'b1110);
    release_all();
  endtask

  task automatic t_holdoff();
    bit seen; int cyc;
    @(negedge clk) key_down[3*4+0] = 1'b1;
    wait_valid(200, seen, cyc);
    chk(seen && key_code == 4'hC, "R4 code col3", key_code, 4'hC);
    repeat (20) @(negedge clk);
    key_down = '0;
    key_down[0*4+2] = 1'b1;
    repeat (HOLD - 3) @(negedge clk);
    chk(col_o == 4'b0111, "R7 frozen", col_o, 4'b0111);
    chk(!key_valid, "R7 quiet", key_valid, 0);
    repeat (8) @(negedge clk);
    chk(col_o == 4'b1110, "R8 restart", col_o, 4'b1110);
    wait_valid(100, seen, cyc);
    cyc = cyc + HOLD + 5;
    chk(seen && key_code == 4'h2, "R8 code", key_code, 4'h2);
    chk(cyc >= HOLD && cyc <= HOLD + SETTLE + 10, "R7 gap", cyc, HOLD + SETTLE);
    release_all();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_idle_scan();
    t_single();
    t_multi_row();
    t_held();
    t_holdoff();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule